// File: doc/BRIEF.md
# Bit String Logic Engine

This engine carries out one command at a time on bit strings held in a word-wide memory. A command names a source bit address, a destination bit address, a length in bits, an operation and a direction of travel. Combining operations merge the source string into the destination string. Search operations scan only the source string for the first bit of a chosen value and report where it lies.

Both strings may begin at any bit inside a word. The engine works one destination word at a time. For each word it reads one or two source words and funnel-shifts them into line with the destination. It then reads the destination word, combines the two and writes the word back under a mask, so that bits outside the addressed range keep their values. When the strings overlap, the direction chooses which end is processed first. A caller picks reverse when the destination lies above the source, and the result is then a true copy of the original source.

Top module: `bse_engine`

## Requirements
- R1: After reset, busy, done, found and mem_req are all low.
- R2: Operation codes 0 to 7 write, for every addressed bit, the following function of source bit s and old destination bit d: 0 move s, 1 not s, 2 d and s, 3 d and not s, 4 d or s, 5 d or not s, 6 d xor s, 7 d xor not s.
- R3: Every memory bit outside the addressed destination range holds its old value after a combining operation.
- R4: Source and destination start at any bit offset. Bit address a lives in word a/32 at bit position a%32. Lengths from one bit to many words give the correct result.
- R5: With reverse=1 the string is processed from its high end downward, and the result matches a copy from the unmodified source. This holds for non-overlapping strings, for overlapping strings whose destination lies above the source when reverse=1, and for those whose destination lies below the source when reverse=0.
- R6: Code 8 searches for the first 0 bit and code 9 for the first 1 bit. In forward direction a match sets found=1, and find_off holds the match's index counted from the source start.
- R7: In reverse direction a search returns the match nearest the high end, and find_off holds its distance from the last bit of the string.
- R8: A search with no match ends with found=0 and find_off=0.
- R9: A command of length 0 raises done on the cycle after start, leaves busy low and makes no memory request.
- R10: Operation codes 10 to 15 behave like a length-0 command and leave memory unchanged.
- R11: done is a one-cycle pulse. busy is high from the cycle after an accepted non-trivial start until the cycle in which done is high, when it is low.
- R12: mem_we is only high together with mem_req. Read data returns one cycle after the request, and every access covers one whole 32-bit word.
- R13: A search never writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken while busy is low |
| op | input | 4 | Operation code |
| reverse | input | 1 | 1: process from the high end downward |
| src_bit | input | AW+5 | Source string start bit address |
| dst_bit | input | AW+5 | Destination string start bit address |
| len | input | LW | String length in bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Search located a match |
| find_off | output | LW | Offset of the match in the direction of travel |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |

## Verification
The bench keeps the default parameters: a 10-bit word address, which gives a 1024-word memory, and a 16-bit length. This leaves room for strings that span several words at any start offset. Source and destination can sit far apart or overlap in both directions. Search fields can start at odd offsets, and a bit-by-bit model checks the whole memory image after every command.

// File: rtl/bse_pkg.sv
package bse_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 5;
  localparam logic [3:0] OP_LAST = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_CHUNK, S_RS0, S_RS1, S_RD, S_WR, S_FIND
  } state_e;

  // n bits set starting at position ofs
  function automatic logic [WORD_W-1:0] field_mask(input logic [5:0] n,
                                                   input logic [OFS_W-1:0] ofs);
    logic [WORD_W-1:0] m;
    m = (n >= 6'd32) ? '1 : ((32'h1 << n) - 32'h1);
    return m << ofs;
  endfunction

  function automatic logic [WORD_W-1:0] combine_op(input logic [3:0] code,
                                                   input logic [WORD_W-1:0] s,
                                                   input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    case (code[2:0])
      3'd0: r = s;
      3'd1: r = ~s;
      3'd2: r = d & s;
      3'd3: r = d & ~s;
      3'd4: r = d | s;
      3'd5: r = d | ~s;
      3'd6: r = d ^ s;
      default: r = d ^ ~s;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bse_chunk.sv
module bse_chunk import bse_pkg::*; #(
  parameter int BA = 15,
  parameter int LW = 16
) (
  input  logic          reverse,
  input  logic          search,
  input  logic [BA-1:0] src,
  input  logic [BA-1:0] dst,
  input  logic [LW-1:0] cnt,
  input  logic [LW-1:0] rem,
  output logic [5:0]    n,
  output logic [BA-1:0] saddr,
  output logic [BA-1:0] daddr
);
  logic [OFS_W-1:0] anchor, pos;
  logic [5:0]       room;
  logic [LW-1:0]    nl, off;

  always_comb begin
    anchor = search ? src[OFS_W-1:0] : dst[OFS_W-1:0];
    if (reverse) begin
      pos  = anchor + rem[OFS_W-1:0] - 5'd1;
      room = {1'b0, pos} + 6'd1;
    end else begin
      pos  = anchor + cnt[OFS_W-1:0];
      room = 6'd32 - {1'b0, pos};
    end
    nl    = (rem < LW'(room)) ? rem : LW'(room);
    n     = nl[5:0];
    off   = reverse ? (rem - nl) : cnt;
    saddr = src + BA'(off);
    daddr = dst + BA'(off);
  end
endmodule

// File: rtl/bse_align.sv
module bse_align import bse_pkg::*; (
  input  logic [3:0]        op,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] hi,
  input  logic [OFS_W-1:0]  s_ofs,
  input  logic [OFS_W-1:0]  d_ofs,
  input  logic [5:0]        n,
  input  logic [WORD_W-1:0] old,
  output logic [WORD_W-1:0] wdata
);
  logic [WORD_W-1:0] al, sh, mask, res;

  always_comb begin
    al    = WORD_W'({hi, lo} >> s_ofs);
    sh    = al << d_ofs;
    mask  = field_mask(n, d_ofs);
    res   = combine_op(op, sh, old);
    wdata = (old & ~mask) | (res & mask);
  end
endmodule

// File: rtl/bse_scan.sv
module bse_scan import bse_pkg::*; (
  input  logic [WORD_W-1:0] word,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [5:0]        n,
  input  logic              want1,
  input  logic              reverse,
  output logic              hit,
  output logic [OFS_W-1:0]  pos
);
  logic [WORD_W-1:0] v;

  always_comb begin
    v   = (want1 ? word : ~word) & field_mask(n, ofs);
    hit = |v;
    pos = '0;
    if (reverse) begin
      for (int i = 0; i < WORD_W; i++)
        if (v[i]) pos = OFS_W'(i);
    end else begin
      for (int i = WORD_W-1; i >= 0; i--)
        if (v[i]) pos = OFS_W'(i);
    end
  end
endmodule

// File: rtl/bse_engine.sv
module bse_engine import bse_pkg::*; #(
  parameter int AW = 10,
  parameter int LW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          op,
  input  logic                reverse,
  input  logic [AW+OFS_W-1:0] src_bit,
  input  logic [AW+OFS_W-1:0] dst_bit,
  input  logic [LW-1:0]       len,
  output logic                busy,
  output logic                done,
  output logic                found,
  output logic [LW-1:0]       find_off,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata
);
  localparam int BA = AW + OFS_W;

  // reset: asserted at once, released on the clock
  logic r_meta, arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_meta <= 1'b0;
      arst_n <= 1'b0;
    end else begin
      r_meta <= 1'b1;
      arst_n <= r_meta;
    end
  end

  state_e        state_q, state_d;
  logic [3:0]    op_q;
  logic          rev_q, need2_q, done_q, found_q;
  logic [BA-1:0] src_q, dst_q, saddr_q, daddr_q;
  logic [LW-1:0] len_q, cnt_q, rem_q, off_q;
  logic [5:0]    n_q;
  logic [WORD_W-1:0] lo_q, hi_q;

  logic          accept, trivial, srch, last, adv;
  logic          done_d, res_ld, found_d;
  logic [LW-1:0] off_d, rel, hit_off;
  logic [5:0]    ch_n;
  logic [BA-1:0] ch_s, ch_d;
  logic          sc_hit;
  logic [OFS_W-1:0] sc_pos;
  logic [WORD_W-1:0] al_wdata;

  assign accept  = (state_q == S_IDLE) && start;
  assign trivial = accept && ((len == '0) || (op > OP_LAST));
  assign srch    = op_q[3];
  assign last    = (rem_q == LW'(n_q));

  bse_chunk #(.BA(BA), .LW(LW)) u_chunk (
    .reverse(rev_q), .search(srch), .src(src_q), .dst(dst_q),
    .cnt(cnt_q), .rem(rem_q), .n(ch_n), .saddr(ch_s), .daddr(ch_d)
  );

  bse_align u_align (
    .op(op_q), .lo(lo_q), .hi(hi_q),
    .s_ofs(saddr_q[OFS_W-1:0]), .d_ofs(daddr_q[OFS_W-1:0]),
    .n(n_q), .old(mem_rdata), .wdata(al_wdata)
  );

  bse_scan u_scan (
    .word(mem_rdata), .ofs(saddr_q[OFS_W-1:0]), .n(n_q),
    .want1(op_q[0]), .reverse(rev_q), .hit(sc_hit), .pos(sc_pos)
  );

  always_comb begin
    rel     = LW'(saddr_q - src_q) + LW'(sc_pos) - LW'(saddr_q[OFS_W-1:0]);
    hit_off = rev_q ? (len_q - LW'(1) - rel) : rel;
  end

  // next state, memory strobes, completion
  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = daddr_q[BA-1:OFS_W];
    mem_wdata = al_wdata;
    adv       = 1'b0;
    done_d    = 1'b0;
    res_ld    = 1'b0;
    found_d   = 1'b0;
    off_d     = '0;
    case (state_q)
      S_IDLE: begin
        if (trivial) begin
          done_d = 1'b1;
          res_ld = 1'b1;
        end else if (accept) begin
          state_d = S_CHUNK;
          res_ld  = 1'b1;
        end
      end
      S_CHUNK: state_d = S_RS0;
      S_RS0: begin
        mem_req  = 1'b1;
        mem_addr = saddr_q[BA-1:OFS_W];
        state_d  = srch ? S_FIND : S_RS1;
      end
      S_RS1: begin
        mem_req  = need2_q;
        mem_addr = saddr_q[BA-1:OFS_W] + AW'(1);
        state_d  = S_RD;
      end
      S_RD: begin
        mem_req = 1'b1;
        state_d = S_WR;
      end
      S_WR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        adv     = 1'b1;
        if (last) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = S_CHUNK;
        end
      end
      S_FIND: begin
        adv = 1'b1;
        if (sc_hit) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
          res_ld  = 1'b1;
          found_d = 1'b1;
          off_d   = hit_off;
        end else if (last) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = S_CHUNK;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      op_q    <= '0;
      rev_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      rem_q   <= '0;
      n_q     <= '0;
      saddr_q <= '0;
      daddr_q <= '0;
      need2_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      off_q   <= '0;
    end else begin
      done_q <= done_d;
      if (accept) begin
        op_q  <= op;
        rev_q <= reverse;
        src_q <= src_bit;
        dst_q <= dst_bit;
        len_q <= len;
        cnt_q <= '0;
        rem_q <= len;
      end
      if (state_q == S_CHUNK) begin
        n_q     <= ch_n;
        saddr_q <= ch_s;
        daddr_q <= ch_d;
        need2_q <= ({2'b00, ch_s[OFS_W-1:0]} + {1'b0, ch_n}) > 7'd32;
      end
      if (state_q == S_RS1) lo_q <= mem_rdata;
      if (state_q == S_RD)  hi_q <= need2_q ? mem_rdata : '0;
      if (adv) begin
        cnt_q <= cnt_q + LW'(n_q);
        rem_q <= rem_q - LW'(n_q);
      end
      if (res_ld) begin
        found_q <= found_d;
        off_q   <= off_d;
      end
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign found    = found_q;
  assign find_off = off_q;
endmodule

// File: rtl/bse_engine_chk.sv
module bse_engine_chk #(
  parameter int LW = 16
) (
  input logic          clk,
  input logic          arst_n,
  input logic          start,
  input logic [3:0]    op,
  input logic [LW-1:0] len,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we
);
  logic srch_l;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              srch_l <= 1'b0;
    else if (start && !busy)  srch_l <= op[3];
  end

  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!arst_n) done |=> !done); // R11
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!arst_n) done |-> !busy); // R11
  AST_BUSY_END:    assert property (@(posedge clk) disable iff (!arst_n) $fell(busy) |-> done); // R11
  AST_START_BUSY:  assert property (@(posedge clk) disable iff (!arst_n)
                     (start && !busy && len != '0 && op <= 4'd9) |=> busy); // R11
  AST_ZERO_LEN:    assert property (@(posedge clk) disable iff (!arst_n)
                     (start && !busy && len == '0) |=> (done && !busy)); // R9
  AST_BAD_OP:      assert property (@(posedge clk) disable iff (!arst_n)
                     (start && !busy && op > 4'd9) |=> (done && !busy)); // R10
  AST_IDLE_NOMEM:  assert property (@(posedge clk) disable iff (!arst_n) !busy |-> !mem_req); // R9
  AST_WE_REQ:      assert property (@(posedge clk) disable iff (!arst_n) mem_we |-> mem_req); // R12
  AST_SEARCH_RO:   assert property (@(posedge clk) disable iff (!arst_n)
                     (busy && srch_l) |-> !mem_we); // R13
endmodule

bind bse_engine bse_engine_chk #(.LW(LW)) u_chk (
  .clk(clk), .arst_n(arst_n), .start(start), .op(op), .len(len),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/sim_bse_engine.sv
module sim_bse_engine;
  localparam int AW = 10;
  localparam int LW = 16;
  localparam int BA = AW + 5;
  localparam int NW = 1 << AW;

  logic          clk, rst_n, start, reverse;
  logic [3:0]    op;
  logic [BA-1:0] src_bit, dst_bit;
  logic [LW-1:0] len;
  logic          busy, done, found, mem_req, mem_we;
  logic [LW-1:0] find_off;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;

  logic [31:0] mem  [NW];
  logic [31:0] snap [NW];
  logic [31:0] expm [NW];
  logic        pk_en;
  logic [AW-1:0] pk_a;
  logic [31:0] pk_d;

  int errors = 0;
  int checks = 0;

  bse_engine #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reverse(reverse),
    .src_bit(src_bit), .dst_bit(dst_bit), .len(len), .busy(busy), .done(done),
    .found(found), .find_off(find_off), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // word memory, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    end else if (pk_en) begin
      mem[pk_a] <= pk_d;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic sbit(input int a);
    return snap[(a >> 5) % NW][a & 31];
  endfunction

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    pk_en = 1'b1; pk_a = AW'(a); pk_d = d;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  // one command with full model comparison
  task automatic run_op(input logic [3:0] o, input logic r, input int s, input int d,
                        input int n, input string tag);
    logic ef, sb, db, nb, hit_seen, trivial;
    int   eo, cyc, reqs, bad_busy, bad_w;
    for (int i = 0; i < NW; i++) begin snap[i] = mem[i]; expm[i] = mem[i]; end
    trivial = (n == 0) || (o > 4'd9);
    ef = 1'b0; eo = 0;
    if (!trivial && o <= 4'd7) begin
      for (int i = 0; i < n; i++) begin
        sb = sbit(s + i); db = sbit(d + i);
        case (o)
          4'd0: nb = sb;        4'd1: nb = !sb;
          4'd2: nb = db && sb;  4'd3: nb = db && !sb;
          4'd4: nb = db || sb;  4'd5: nb = db || !sb;
          4'd6: nb = db ^ sb;   default: nb = !(db ^ sb);
        endcase
        expm[((d + i) >> 5) % NW][(d + i) & 31] = nb;
      end
    end else if (!trivial) begin
      hit_seen = 1'b0;
      for (int k = 0; k < n; k++) begin
        int i;
        i = r ? (n - 1 - k) : k;
        if (!hit_seen && sbit(s + i) == o[0]) begin
          hit_seen = 1'b1; ef = 1'b1; eo = k;
        end
      end
    end
    @(negedge clk);
    start = 1'b1; op = o; reverse = r;
    src_bit = BA'(s); dst_bit = BA'(d); len = LW'(n);
    @(negedge clk);
    start = 1'b0;
    cyc = 0; reqs = 0; bad_busy = 0;
    while (!done && cyc < 5000) begin
      if (!busy) bad_busy++;
      if (mem_req) reqs++;
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 5000, {"R11 done reached ", tag}, cyc, 0);
    chk(!busy && bad_busy == 0, {"R11 busy during command ", tag}, bad_busy, 0);
    if (trivial) chk(cyc == 0 && reqs == 0, {"R9 R10 immediate no access ", tag}, reqs, 0);
    bad_w = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== expm[i]) begin
      if (bad_w == 0)
        $display("FAIL R2 R3 R12 %s word %0d actual=%0h expected=%0h", tag, i, mem[i], expm[i]);
      bad_w++;
    end
    checks++;
    if (bad_w != 0) errors++;
    if (o >= 4'd8 && o <= 4'd9 && !trivial) begin
      chk(found == ef, {"R6 R7 R8 found ", tag}, found, ef);
      chk(find_off == LW'(eo), {"R6 R7 R8 offset ", tag}, find_off, eo);
    end
    @(negedge clk);
    chk(!done, {"R11 done one cycle ", tag}, done, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !found && !mem_req, "R1 reset state",
        {busy, done, found, mem_req}, 0);
  endtask

  task automatic t_combine;
    for (int o = 0; o < 8; o++)
      run_op(4'(o), 1'b0, 100 + o * 37, 12000 + o * 101, 70 + o * 5, "R2 R3 R4 fwd");
  endtask

  task automatic t_shapes;
    run_op(4'd0, 1'b0, 5, 20003, 1, "R4 single bit");
    run_op(4'd6, 1'b0, 64, 20096, 32, "R4 aligned word");
    run_op(4'd4, 1'b0, 131, 20210, 9, "R4 inside word");
    run_op(4'd0, 1'b0, 31, 20401, 300, "R4 long span");
  endtask

  task automatic t_reverse;
    for (int o = 0; o < 8; o++)
      run_op(4'(o), 1'b1, 700 + o * 29, 15000 + o * 97, 60 + o * 11, "R5 rev");
    run_op(4'd0, 1'b1, 3000, 3017, 90, "R5 overlap up rev");
    run_op(4'd0, 1'b0, 3600, 3590, 80, "R5 overlap down fwd");
  endtask

  task automatic t_search;
    for (int w = 200; w < 204; w++) poke(w, 32'h0);
    poke(202, 32'h0000_2000);
    poke(200, 32'h4000_0000);
    run_op(4'd9, 1'b0, 6405, 0, 100, "R6 first one fwd");
    run_op(4'd9, 1'b1, 6405, 0, 100, "R7 first one rev");
    run_op(4'd9, 1'b0, 6480, 0, 40, "R8 no one");
    poke(210, 32'hFFFF_FFFF);
    poke(211, 32'hFFFF_FEFF);
    run_op(4'd8, 1'b0, 6723, 0, 60, "R6 first zero fwd");
    run_op(4'd8, 1'b1, 6723, 0, 60, "R7 first zero rev");
    run_op(4'd8, 1'b0, 6720, 0, 32, "R8 no zero");
    run_op(4'd9, 1'b1, 6400, 0, 128, "R13 search keeps memory");
  endtask

  task automatic t_trivial;
    run_op(4'd0, 1'b0, 10, 9000, 0, "R9 zero length");
    run_op(4'd12, 1'b0, 10, 9000, 20, "R10 bad code 12");
    run_op(4'd15, 1'b1, 10, 9000, 20, "R10 bad code 15");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; reverse = 1'b0;
    src_bit = '0; dst_bit = '0; len = '0; pk_en = 1'b0; pk_a = '0; pk_d = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_combine();
    t_shapes();
    t_reverse();
    t_search();
    t_trivial();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule